// File: doc/BRIEF.md
# Masked condition-field logic unit

This unit rewrites one 4-bit field of a 32-bit condition register. The register is split into eight fields, and a 3-bit selector names each one. On every bit position of the destination field, the unit computes a small bitwise function. A 4-bit write mask then decides which bits of the destination field take the new value. Unmasked bits and every other field pass through unchanged.

Two modes are supported. In ternary-immediate mode, each bit of the destination, source-A and source-B fields forms a 3-bit index into an 8-bit immediate table. In dynamic-binary mode, each bit of the destination and source-A fields forms a 2-bit index into a 4-bit table, and that table is the field named by the source-B selector. A mask of all zeros is illegal. It raises a one-cycle trap flag and leaves the register untouched.

Control is a three-state machine that records the outcome of the previous cycle:
- ST_IDLE means no operation was taken.
- ST_WRITE means a legal operation was committed.
- ST_TRAP means an all-zero mask was rejected.

From every state, the next state is chosen the same way:
- A valid strobe with a zero mask goes to ST_TRAP.
- A valid strobe with a non-zero mask goes to ST_WRITE.
- No strobe goes to ST_IDLE.

The trap flag is high exactly while the machine is in ST_TRAP.

Top module: `cond_field_logic`

## Requirements
- R1: While reset is asserted, and after it is released, `cr_o` is 0 and `illegal_o` is 0 until the first valid operation.
- R2: Field n occupies bits [4n+3:4n] of the condition register, and the selectors `dst_i`, `src_a_i` and `src_b_i` name fields by n.
- R3: With `mode_i`=0 (ternary), the candidate for field bit i is bit j of `imm_i`, where j = 4·dst[i] + 2·A[i] + B[i].
- R4: With `mode_i`=1 (binary), the candidate for field bit i is bit j of the field named by `src_b_i`, where j = 2·dst[i] + A[i]; `imm_i` is ignored.
- R5: Mask bit i (`mask_i[i]`, counted from the LSB) enables the write of destination-field bit i; a destination bit whose mask bit is 0 keeps its value from `cr_i`.
- R6: All bits outside the destination field equal the corresponding bits of `cr_i`.
- R7: A valid operation with `mask_i`=0 makes `illegal_o` high for exactly the following cycle, and `cr_o` then equals that cycle's `cr_i` unchanged.
- R8: When the destination field is also a source field, every read uses the `cr_i` values from before the update.
- R9: The result appears on `cr_o` after the clock edge that samples `valid_i`; without `valid_i`, `cr_o` holds and `illegal_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| mode_i | input | 1 | 0 = ternary immediate, 1 = dynamic binary |
| cr_i | input | 32 | Condition register before the update |
| dst_i | input | 3 | Destination field selector |
| src_a_i | input | 3 | Source A field selector |
| src_b_i | input | 3 | Source B field selector (table field in binary mode) |
| imm_i | input | 8 | Ternary lookup table |
| mask_i | input | 4 | Per-bit write mask for the destination field |
| cr_o | output | 32 | Updated condition register |
| illegal_o | output | 1 | One-cycle illegal-mask pulse |

## Verification
The bench tries every combination of destination, A and B selectors in both modes. It repeats the sweep over several pseudo-random register contents, tables and masks. Because the sweep includes every aliasing case, a wrong read-before-write order shows up (R8). It also separates a misplaced field offset from a wrong index bit order, and a table taken from the wrong field from one taken from the immediate. A separate sweep walks all sixteen mask values with fixed data, which distinguishes per-bit masking from whole-field writes and exercises the zero-mask trap. After every operation, an idle cycle with changed input data confirms that the register holds.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
    typedef enum logic {
        MODE_TERN = 1'b0,
        MODE_BIN  = 1'b1
    } cfl_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_TRAP  = 2'd2
    } cfl_state_e;
endpackage

// File: rtl/cfl_field_sel.sv
module cfl_field_sel #(
    parameter int NUM_FIELDS = 8,
    parameter int FIELD_W    = 4,
    localparam int CR_W      = NUM_FIELDS * FIELD_W,
    localparam int SEL_W     = $clog2(NUM_FIELDS)
) (
    input  logic [CR_W-1:0]    cr_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic [FIELD_W-1:0] field_o
);
    always_comb begin
        field_o = '0;
        for (int f = 0; f < NUM_FIELDS; f++) begin
            if (sel_i == SEL_W'(f)) begin
                field_o = cr_i[f*FIELD_W +: FIELD_W];
            end
        end
    end
endmodule

// File: rtl/cfl_lut_eval.sv
module cfl_lut_eval #(
    parameter int FIELD_W = 4,
    localparam int IMM_W  = 8
) (
    input  logic               mode_i,
    input  logic [FIELD_W-1:0] d_i,
    input  logic [FIELD_W-1:0] a_i,
    input  logic [FIELD_W-1:0] b_i,
    input  logic [IMM_W-1:0]   imm_i,
    output logic [FIELD_W-1:0] cand_o
);
    import cfl_pkg::*;

    for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
        logic [2:0] tern_idx;
        logic [1:0] bin_idx;
        assign tern_idx  = {d_i[i], a_i[i], b_i[i]};
        assign bin_idx   = {d_i[i], a_i[i]};
        assign cand_o[i] = (mode_i == MODE_BIN) ? b_i[bin_idx] : imm_i[tern_idx];
    end
endmodule

// File: rtl/cfl_merge.sv
module cfl_merge #(
    parameter int NUM_FIELDS = 8,
    parameter int FIELD_W    = 4,
    localparam int CR_W      = NUM_FIELDS * FIELD_W,
    localparam int SEL_W     = $clog2(NUM_FIELDS)
) (
    input  logic [CR_W-1:0]    cr_i,
    input  logic [SEL_W-1:0]   dst_i,
    input  logic [FIELD_W-1:0] cand_i,
    input  logic [FIELD_W-1:0] mask_i,
    output logic [CR_W-1:0]    cr_o
);
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        logic hit;
        assign hit = (dst_i == SEL_W'(f));
        for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
            assign cr_o[f*FIELD_W + i] = (hit && mask_i[i]) ? cand_i[i] : cr_i[f*FIELD_W + i];
        end
    end
endmodule

// File: rtl/cond_field_logic.sv
module cond_field_logic #(
    parameter int NUM_FIELDS = 8,
    parameter int FIELD_W    = 4,
    localparam int CR_W      = NUM_FIELDS * FIELD_W,
    localparam int SEL_W     = $clog2(NUM_FIELDS),
    localparam int IMM_W     = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               valid_i,
    input  logic               mode_i,
    input  logic [CR_W-1:0]    cr_i,
    input  logic [SEL_W-1:0]   dst_i,
    input  logic [SEL_W-1:0]   src_a_i,
    input  logic [SEL_W-1:0]   src_b_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic [FIELD_W-1:0] mask_i,
    output logic [CR_W-1:0]    cr_o,
    output logic               illegal_o
);
    import cfl_pkg::*;

    logic [FIELD_W-1:0] fld_d, fld_a, fld_b, cand;
    logic [CR_W-1:0]    merged;
    logic               mask_zero;
    cfl_state_e         state_q, state_d;
    logic [CR_W-1:0]    cr_q;

    cfl_field_sel #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_sel_d (
        .cr_i(cr_i), .sel_i(dst_i), .field_o(fld_d));
    cfl_field_sel #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_sel_a (
        .cr_i(cr_i), .sel_i(src_a_i), .field_o(fld_a));
    cfl_field_sel #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_sel_b (
        .cr_i(cr_i), .sel_i(src_b_i), .field_o(fld_b));

    cfl_lut_eval #(.FIELD_W(FIELD_W)) u_eval (
        .mode_i(mode_i), .d_i(fld_d), .a_i(fld_a), .b_i(fld_b),
        .imm_i(imm_i), .cand_o(cand));

    cfl_merge #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_merge (
        .cr_i(cr_i), .dst_i(dst_i), .cand_i(cand), .mask_i(mask_i), .cr_o(merged));

    assign mask_zero = (mask_i == '0);

    // Next-state selection: identical targets from every state.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_WRITE, ST_TRAP: begin
                if (valid_i && mask_zero)  state_d = ST_TRAP;
                else if (valid_i)          state_d = ST_WRITE;
                else                       state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Register datapath: commits on the same edge the state moves
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cr_q <= '0;
        end else if (valid_i) begin
            cr_q <= mask_zero ? cr_i : merged;
        end
    end

    // Outputs decoded from state
    always_comb begin
        illegal_o = 1'b0;
        unique case (state_q)
            ST_TRAP:         illegal_o = 1'b1;
            ST_IDLE, ST_WRITE: illegal_o = 1'b0;
            default:         illegal_o = 1'b0;
        endcase
    end

    assign cr_o = cr_q;
endmodule

// File: rtl/cfl_checker.sv
module cfl_checker #(
    parameter int NUM_FIELDS = 8,
    parameter int FIELD_W    = 4,
    localparam int CR_W      = NUM_FIELDS * FIELD_W,
    localparam int SEL_W     = $clog2(NUM_FIELDS)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               valid_i,
    input logic [CR_W-1:0]    cr_i,
    input logic [SEL_W-1:0]   dst_i,
    input logic [FIELD_W-1:0] mask_i,
    input logic [CR_W-1:0]    cr_o,
    input logic               illegal_o
);
    logic [CR_W-1:0] wr_bits;
    assign wr_bits = CR_W'(mask_i) << (int'(dst_i) * FIELD_W);

    assert_trap_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && mask_i == '0) |=> (illegal_o && cr_o == $past(cr_i)));

    assert_no_spurious_trap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !illegal_o);

    assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> $stable(cr_o));

    assert_unmasked_untouched_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && mask_i != '0) |=> (((cr_o ^ $past(cr_i)) & ~$past(wr_bits)) == '0));

    assert_legal_no_trap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && mask_i != '0) |=> !illegal_o);
endmodule

bind cond_field_logic cfl_checker #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .cr_i(cr_i), .dst_i(dst_i),
    .mask_i(mask_i), .cr_o(cr_o), .illegal_o(illegal_o));

// File: tb/cond_field_logic_tb.sv
module cond_field_logic_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic        mode = 1'b0;
    logic [31:0] cr_in = '0;
    logic [2:0]  dst = '0, sa = '0, sb = '0;
    logic [7:0]  imm = '0;
    logic [3:0]  mask = '0;
    logic [31:0] cr_out;
    logic        illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cond_field_logic u_dut (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .mode_i(mode), .cr_i(cr_in),
        .dst_i(dst), .src_a_i(sa), .src_b_i(sb), .imm_i(imm), .mask_i(mask),
        .cr_o(cr_out), .illegal_o(illegal));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic m, input logic [31:0] cr, input int d,
                                          input int a, input int b, input logic [7:0] tb_imm,
                                          input logic [3:0] msk);
        logic [31:0] res = cr;
        if (msk == 4'd0) return cr;
        for (int i = 0; i < 4; i++) begin
            int dv = int'(cr[4*d+i]);
            int av = int'(cr[4*a+i]);
            int bv = int'(cr[4*b+i]);
            logic v;
            if (m == 1'b0) v = tb_imm[4*dv + 2*av + bv];
            else           v = cr[4*b + 2*dv + av];
            if (msk[i]) res[4*d+i] = v;
        end
        return res;
    endfunction

    task automatic run_op(input logic m, input int d, input int a, input int b,
                          input logic [7:0] t, input logic [3:0] msk, input logic [31:0] cr,
                          input string tag);
        logic [31:0] exp;
        logic [31:0] held;
        exp = model(m, cr, d, a, b, t, msk);
        @(negedge clk);
        valid = 1'b1; mode = m; cr_in = cr; dst = 3'(d); sa = 3'(a); sb = 3'(b);
        imm = t; mask = msk;
        @(posedge clk); #1;
        chk(cr_out == exp, tag, cr_out, exp);
        chk(illegal == (msk == 4'd0), "R7 illegal flag", 32'(illegal), 32'(msk == 4'd0));
        held = cr_out;
        @(negedge clk);
        valid = 1'b0; cr_in = ~cr; mask = 4'd0;
        @(posedge clk); #1;
        chk(cr_out == held && !illegal, "R9 hold without valid", cr_out, held);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed = 32'h1234_5678;
        repeat (3) @(posedge clk);
        #1;
        chk(cr_out == 32'd0 && !illegal, "R1 during reset", cr_out, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(cr_out == 32'd0 && !illegal, "R1 after release", cr_out, 32'd0);

        // Full selector sweep in both modes over several data patterns (R2, R3, R4, R5, R6, R8)
        for (int p = 0; p < 3; p++) begin
            for (int m = 0; m < 2; m++) begin
                for (int d = 0; d < 8; d++) begin
                    for (int a = 0; a < 8; a++) begin
                        for (int b = 0; b < 8; b++) begin
                            logic [7:0] t;
                            logic [3:0] msk;
                            string tag;
                            seed = seed * 32'd1103515245 + 32'd12345;
                            t   = seed[23:16] ^ 8'(p * 37 + d);
                            msk = (p == 0) ? 4'hF : ((seed[11:8] == 4'd0) ? 4'h5 : seed[11:8]);
                            if (d == a || d == b)  tag = "R8 aliased fields";
                            else if (m == 0)       tag = "R3 ternary R2 R6";
                            else                   tag = "R4 binary R2 R6";
                            run_op(m[0], d, a, b, t, msk, seed ^ {seed[15:0], seed[31:16]}, tag);
                        end
                    end
                end
            end
        end

        // Mask sweep with fixed data (R5, R7)
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 16; k++) begin
                run_op(m[0], 5, 2, 6, 8'hB4, 4'(k), 32'h0A5C_33F0, "R5 mask sweep R7");
            end
        end

        // Binary mode ignores the immediate (R4)
        run_op(1'b1, 1, 3, 7, 8'h00, 4'hF, 32'h9000_6050, "R4 imm zero");
        run_op(1'b1, 1, 3, 7, 8'hFF, 4'hF, 32'h9000_6050, "R4 imm ones");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule